// File: doc/BRIEF.md
# Two-Port GPIO Output Register Block with Local and Peripheral Bus Access

This block holds the output-driver-enable and output-level registers for two 32-bit GPIO ports, together with a read-only sampled copy of each port's pad inputs. A single-cycle CPU-local bus and a slower peripheral bus with a valid/ready handshake can both reach the same physical registers. Every output register has four write addresses. One loads the data word. One sets the bits that are 1 in the data. One clears them. One inverts them. Software can therefore change any subset of pins without a read-modify-write.

The local bus accepts one access per clock cycle and always has the same latency. Code running on the CPU can therefore drive pins with exactly known timing, for example toggling a pin on every cycle. The peripheral bus gives general access to the same registers, and its reads return the register contents. Pad inputs pass through a two-stage synchronizer before they reach the readable pin register. The enable and level vectors are driven straight from the registers toward the pads.

Both buses use a 9-bit byte address. Bit 8 selects the port (0 or 1). Bits 7:0 are the offset within that port. Address bits 1:0 are ignored.

Top module: `gpio_dual_bus`

## Requirements
- R1: In reset, every output-enable and output-level register is cleared to zero. After reset, `pb_ready` is low and `lb_rdata` is zero.
- R2: A write to offset 0x40 (enable) or 0x50 (level) loads the data word into that register. The new value appears on `oe_out`/`ov_out` in the cycle after the write.
- R3: A write to offset 0x44 (enable) or 0x54 (level) ORs the data into the register.
- R4: A write to offset 0x48 (enable) or 0x58 (level) clears the register bits that are 1 in the data.
- R5: A write to offset 0x4C (enable) or 0x5C (level) inverts the register bits that are 1 in the data.
- R6: Port 1 has the same layout as port 0, 0x100 higher. A write to one port leaves the other port unchanged. Port p occupies bits [32p+31:32p] of `pin_in`, `oe_out` and `ov_out`.
- R7: A local-bus read returns its data on `lb_rdata` one cycle after the request. Offset 0x60 returns the port's synchronized pin value. All eight output-register offsets read as zero.
- R8: Writes to offset 0x60 or to any unmapped offset, from either bus, change no register.
- R9: On the peripheral bus, `pb_ready` rises one cycle after `pb_valid` and stays high for a single cycle. A write takes effect at that handshake edge, using the same offsets and operations as the local bus.
- R10: A peripheral-bus read returns data during the handshake cycle:
  - offset 0x40 returns the enable register;
  - offset 0x50 returns the level register;
  - offset 0x60 returns the pin value;
  - every other offset returns zero.
- R11: When both buses write the same register in the same cycle, the peripheral operation is applied first and the local operation is applied to its result. Operations from the two buses on disjoint bits both take effect.
- R12: A change on `pin_in` becomes visible in the pin-value register after two clock edges.
- R13: The local bus can write on consecutive cycles. A toggle held for several cycles changes the pad level on every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lb_en | input | 1 | Local-bus access strobe |
| lb_we | input | 1 | Local-bus write (1) or read (0) |
| lb_addr | input | 9 | Local-bus byte address (bit 8 = port) |
| lb_wdata | input | 32 | Local-bus write data |
| lb_rdata | output | 32 | Local-bus read data, one cycle after request |
| pb_valid | input | 1 | Peripheral request valid, held until ready |
| pb_write | input | 1 | Peripheral write (1) or read (0) |
| pb_addr | input | 9 | Peripheral byte address (bit 8 = port) |
| pb_wdata | input | 32 | Peripheral write data |
| pb_ready | output | 1 | Peripheral handshake completion |
| pb_rdata | output | 32 | Peripheral read data, valid with ready |
| pin_in | input | 64 | Pad input levels, 32 per port |
| oe_out | output | 64 | Output-driver enables toward pads |
| ov_out | output | 64 | Output levels toward pads |

## Verification
The hardest case to reach from the ports is a same-cycle collision, where a peripheral write and a local write hit one register at the same clock edge. The bench starts a peripheral transfer and waits through its wait state until `pb_ready` is high. Only then does it raise the local-bus write, so that both operations land on the same edge. It does this once with an overlapping load-then-toggle, where the order of application decides the result. It does it again with a set and a clear on disjoint bits. The timing of the synchronizer is pinned down by a stream of local reads issued on consecutive cycles while one pin changes.

// File: rtl/gpio_dual_pkg.sv
package gpio_dual_pkg;

    parameter int GPIO_DW   = 32;
    parameter int GPIO_NP   = 2;
    parameter int GPIO_OFFW = 8;

    localparam logic [3:0] GRP_OE = 4'h4;
    localparam logic [3:0] GRP_OV = 4'h5;
    localparam logic [3:0] GRP_PV = 4'h6;

    typedef enum logic [1:0] {
        OP_LOAD = 2'd0,
        OP_SET  = 2'd1,
        OP_CLR  = 2'd2,
        OP_TGL  = 2'd3
    } wop_e;

    typedef enum logic [1:0] {
        TGT_NONE = 2'd0,
        TGT_OE   = 2'd1,
        TGT_OV   = 2'd2,
        TGT_PV   = 2'd3
    } tgt_e;

    typedef struct packed {
        logic                 valid;
        tgt_e                 tgt;
        wop_e                 op;
        logic [GPIO_DW-1:0]   data;
    } wreq_t;

    function automatic tgt_e decode_tgt(input logic [GPIO_OFFW-1:0] off);
        tgt_e t;
        unique case (off[7:4])
            GRP_OE:  t = TGT_OE;
            GRP_OV:  t = TGT_OV;
            GRP_PV:  t = (off[3:2] == 2'd0) ? TGT_PV : TGT_NONE;
            default: t = TGT_NONE;
        endcase
        return t;
    endfunction

    function automatic wreq_t make_req(input logic hit,
                                       input logic [GPIO_OFFW-1:0] off,
                                       input logic [GPIO_DW-1:0] data);
        wreq_t r;
        r.tgt   = decode_tgt(off);
        r.op    = wop_e'(off[3:2]);
        r.data  = data;
        r.valid = hit && (r.tgt == TGT_OE || r.tgt == TGT_OV);
        return r;
    endfunction

    function automatic logic [GPIO_DW-1:0] apply_op(input logic [GPIO_DW-1:0] cur,
                                                    input wop_e op,
                                                    input logic [GPIO_DW-1:0] d);
        logic [GPIO_DW-1:0] n;
        unique case (op)
            OP_LOAD: n = d;
            OP_SET:  n = cur | d;
            OP_CLR:  n = cur & ~d;
            OP_TGL:  n = cur ^ d;
            default: n = cur;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/gpio_lb_if.sv
module gpio_lb_if
    import gpio_dual_pkg::*;
#(
    parameter int NPORT  = GPIO_NP,
    parameter int DW     = GPIO_DW,
    localparam int PSELW = (NPORT > 1) ? $clog2(NPORT) : 1,
    localparam int ADDRW = GPIO_OFFW + PSELW
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      lb_en,
    input  logic                      lb_we,
    input  logic [ADDRW-1:0]          lb_addr,
    input  logic [DW-1:0]             lb_wdata,
    input  logic [NPORT-1:0][DW-1:0]  pv,
    output wreq_t [NPORT-1:0]         req,
    output logic [DW-1:0]             lb_rdata
);

    logic [PSELW-1:0]     psel;
    logic [GPIO_OFFW-1:0] off;
    tgt_e                 rd_tgt;
    logic [DW-1:0]        rd_next;

    assign psel   = lb_addr[ADDRW-1:GPIO_OFFW];
    assign off    = lb_addr[GPIO_OFFW-1:0];
    assign rd_tgt = decode_tgt(off);

    for (genvar p = 0; p < NPORT; p++) begin : g_req
        assign req[p] = make_req(lb_en && lb_we && (psel == PSELW'(p)), off, lb_wdata);
    end

    always_comb begin
        rd_next = '0;
        for (int p = 0; p < NPORT; p++) begin
            if (lb_en && !lb_we && rd_tgt == TGT_PV && psel == PSELW'(p))
                rd_next = pv[p];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) lb_rdata <= '0;
        else     lb_rdata <= rd_next;
    end

    a_r7_wo_alias_reads_zero: assert property (@(posedge clk) disable iff (rst)
        (lb_en && !lb_we && (off[7:4] == GRP_OE || off[7:4] == GRP_OV)) |=> (lb_rdata == '0));

    a_r13_single_port_per_cycle: assert property (@(posedge clk) disable iff (rst)
        $countones({req[NPORT-1].valid, req[0].valid}) <= 1);

endmodule

// File: rtl/gpio_pb_if.sv
module gpio_pb_if
    import gpio_dual_pkg::*;
#(
    parameter int NPORT  = GPIO_NP,
    parameter int DW     = GPIO_DW,
    localparam int PSELW = (NPORT > 1) ? $clog2(NPORT) : 1,
    localparam int ADDRW = GPIO_OFFW + PSELW
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      pb_valid,
    input  logic                      pb_write,
    input  logic [ADDRW-1:0]          pb_addr,
    input  logic [DW-1:0]             pb_wdata,
    input  logic [NPORT-1:0][DW-1:0]  oe,
    input  logic [NPORT-1:0][DW-1:0]  ov,
    input  logic [NPORT-1:0][DW-1:0]  pv,
    output wreq_t [NPORT-1:0]         req,
    output logic                      pb_ready,
    output logic [DW-1:0]             pb_rdata
);

    logic [PSELW-1:0]     psel;
    logic [GPIO_OFFW-1:0] off;
    logic                 xfer;

    assign psel = pb_addr[ADDRW-1:GPIO_OFFW];
    assign off  = pb_addr[GPIO_OFFW-1:0];
    assign xfer = pb_valid && pb_ready;

    // one wait state: ready is a single-cycle pulse one cycle after valid
    always_ff @(posedge clk) begin
        if (rst) pb_ready <= 1'b0;
        else     pb_ready <= pb_valid && !pb_ready;
    end

    for (genvar p = 0; p < NPORT; p++) begin : g_req
        assign req[p] = make_req(xfer && pb_write && (psel == PSELW'(p)), off, pb_wdata);
    end

    always_comb begin
        pb_rdata = '0;
        for (int p = 0; p < NPORT; p++) begin
            if (xfer && !pb_write && psel == PSELW'(p)) begin
                if (off[3:2] == 2'd0) begin
                    unique case (off[7:4])
                        GRP_OE:  pb_rdata = oe[p];
                        GRP_OV:  pb_rdata = ov[p];
                        GRP_PV:  pb_rdata = pv[p];
                        default: pb_rdata = '0;
                    endcase
                end
            end
        end
    end

    a_r9_ready_one_cycle: assert property (@(posedge clk) disable iff (rst)
        pb_ready |=> !pb_ready);

    a_r9_ready_follows_valid: assert property (@(posedge clk) disable iff (rst)
        $rose(pb_ready) |-> $past(pb_valid));

endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
    import gpio_dual_pkg::*;
#(
    parameter int DW = GPIO_DW
) (
    input  logic           clk,
    input  logic           rst,
    input  wreq_t          pb_req,
    input  wreq_t          lb_req,
    input  logic [DW-1:0]  pin,
    output logic [DW-1:0]  oe,
    output logic [DW-1:0]  ov,
    output logic [DW-1:0]  pv
);

    logic [DW-1:0] oe_mid, ov_mid, oe_nxt, ov_nxt;
    logic [DW-1:0] sync1;

    // peripheral operation first, local operation applied on top
    always_comb begin
        oe_mid = oe;
        ov_mid = ov;
        if (pb_req.valid && pb_req.tgt == TGT_OE) oe_mid = apply_op(oe, pb_req.op, pb_req.data);
        if (pb_req.valid && pb_req.tgt == TGT_OV) ov_mid = apply_op(ov, pb_req.op, pb_req.data);
        oe_nxt = oe_mid;
        ov_nxt = ov_mid;
        if (lb_req.valid && lb_req.tgt == TGT_OE) oe_nxt = apply_op(oe_mid, lb_req.op, lb_req.data);
        if (lb_req.valid && lb_req.tgt == TGT_OV) ov_nxt = apply_op(ov_mid, lb_req.op, lb_req.data);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            oe    <= '0;
            ov    <= '0;
            sync1 <= '0;
            pv    <= '0;
        end else begin
            oe    <= oe_nxt;
            ov    <= ov_nxt;
            sync1 <= pin;
            pv    <= sync1;
        end
    end

    logic [1:0] since_rst;
    always_ff @(posedge clk) begin
        if (rst)                 since_rst <= '0;
        else if (since_rst != 2) since_rst <= since_rst + 2'd1;
    end

    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> (oe == '0 && ov == '0));

    a_r8_idle_holds: assert property (@(posedge clk) disable iff (rst)
        (!pb_req.valid && !lb_req.valid) |=> ($stable(oe) && $stable(ov)));

    a_r11_local_last: assert property (@(posedge clk) disable iff (rst)
        (pb_req.valid && lb_req.valid && lb_req.tgt == TGT_OV && lb_req.op == OP_LOAD)
        |=> (ov == $past(lb_req.data)));

    a_r12_two_stage: assert property (@(posedge clk) disable iff (rst)
        (since_rst == 2) |-> (pv == $past(pin, 2)));

endmodule

// File: rtl/gpio_dual_bus.sv
module gpio_dual_bus
    import gpio_dual_pkg::*;
#(
    parameter int NPORT  = GPIO_NP,
    parameter int DW     = GPIO_DW,
    localparam int PSELW = (NPORT > 1) ? $clog2(NPORT) : 1,
    localparam int ADDRW = GPIO_OFFW + PSELW
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 lb_en,
    input  logic                 lb_we,
    input  logic [ADDRW-1:0]     lb_addr,
    input  logic [DW-1:0]        lb_wdata,
    output logic [DW-1:0]        lb_rdata,
    input  logic                 pb_valid,
    input  logic                 pb_write,
    input  logic [ADDRW-1:0]     pb_addr,
    input  logic [DW-1:0]        pb_wdata,
    output logic                 pb_ready,
    output logic [DW-1:0]        pb_rdata,
    input  logic [NPORT*DW-1:0]  pin_in,
    output logic [NPORT*DW-1:0]  oe_out,
    output logic [NPORT*DW-1:0]  ov_out
);

    logic [NPORT-1:0][DW-1:0] oe_v, ov_v, pv_v, pin_v;
    wreq_t [NPORT-1:0]        lb_req, pb_req;

    assign pin_v  = pin_in;
    assign oe_out = oe_v;
    assign ov_out = ov_v;

    gpio_lb_if #(.NPORT(NPORT), .DW(DW)) u_lb (
        .clk      (clk),
        .rst      (rst),
        .lb_en    (lb_en),
        .lb_we    (lb_we),
        .lb_addr  (lb_addr),
        .lb_wdata (lb_wdata),
        .pv       (pv_v),
        .req      (lb_req),
        .lb_rdata (lb_rdata)
    );

    gpio_pb_if #(.NPORT(NPORT), .DW(DW)) u_pb (
        .clk      (clk),
        .rst      (rst),
        .pb_valid (pb_valid),
        .pb_write (pb_write),
        .pb_addr  (pb_addr),
        .pb_wdata (pb_wdata),
        .oe       (oe_v),
        .ov       (ov_v),
        .pv       (pv_v),
        .req      (pb_req),
        .pb_ready (pb_ready),
        .pb_rdata (pb_rdata)
    );

    for (genvar p = 0; p < NPORT; p++) begin : g_port
        gpio_port_regs #(.DW(DW)) u_regs (
            .clk    (clk),
            .rst    (rst),
            .pb_req (pb_req[p]),
            .lb_req (lb_req[p]),
            .pin    (pin_v[p]),
            .oe     (oe_v[p]),
            .ov     (ov_v[p]),
            .pv     (pv_v[p])
        );
    end

    a_r6_write_one_port: assert property (@(posedge clk) disable iff (rst)
        (lb_en && lb_we && !pb_valid && lb_addr[ADDRW-1] == 1'b1)
        |=> ($stable(oe_v[0]) && $stable(ov_v[0])));

endmodule

// File: tb/test_gpio_dual_bus.sv
module test_gpio_dual_bus;

    localparam int DW = 32;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            lb_en = 1'b0, lb_we = 1'b0;
    logic [8:0]      lb_addr = '0;
    logic [DW-1:0]   lb_wdata = '0;
    logic [DW-1:0]   lb_rdata;
    logic            pb_valid = 1'b0, pb_write = 1'b0;
    logic [8:0]      pb_addr = '0;
    logic [DW-1:0]   pb_wdata = '0;
    logic            pb_ready;
    logic [DW-1:0]   pb_rdata;
    logic [2*DW-1:0] pin_in = '0;
    logic [2*DW-1:0] oe_out, ov_out;

    int n_chk = 0;
    int n_err = 0;

    always #4 clk = ~clk;

    gpio_dual_bus i_gpio_dual_bus (
        .clk(clk), .rst(rst),
        .lb_en(lb_en), .lb_we(lb_we), .lb_addr(lb_addr), .lb_wdata(lb_wdata), .lb_rdata(lb_rdata),
        .pb_valid(pb_valid), .pb_write(pb_write), .pb_addr(pb_addr), .pb_wdata(pb_wdata),
        .pb_ready(pb_ready), .pb_rdata(pb_rdata),
        .pin_in(pin_in), .oe_out(oe_out), .ov_out(ov_out)
    );

    typedef struct packed {
        logic [8:0]    addr;
        logic [31:0]   data;
        logic [31:0]   oe0, ov0, oe1, ov1;
        logic [3:0]    req;
    } vec_t;

    localparam int NV = 16;
    localparam vec_t VECS [NV] = '{
        '{9'h040, 32'hFFFF0000, 32'hFFFF0000, 32'h00000000, 32'h0, 32'h0, 4'd2},  // R2
        '{9'h050, 32'h12345678, 32'hFFFF0000, 32'h12345678, 32'h0, 32'h0, 4'd2},  // R2
        '{9'h054, 32'h0000000F, 32'hFFFF0000, 32'h1234567F, 32'h0, 32'h0, 4'd3},  // R3
        '{9'h058, 32'h12300000, 32'hFFFF0000, 32'h0004567F, 32'h0, 32'h0, 4'd4},  // R4
        '{9'h05C, 32'hFFFF0000, 32'hFFFF0000, 32'hFFFB567F, 32'h0, 32'h0, 4'd5},  // R5
        '{9'h044, 32'h000000FF, 32'hFFFF00FF, 32'hFFFB567F, 32'h0, 32'h0, 4'd3},  // R3
        '{9'h048, 32'hF0F000F0, 32'h0F0F000F, 32'hFFFB567F, 32'h0, 32'h0, 4'd4},  // R4
        '{9'h04C, 32'h0000FFFF, 32'h0F0FFFF0, 32'hFFFB567F, 32'h0, 32'h0, 4'd5},  // R5
        '{9'h140, 32'hA5A5A5A5, 32'h0F0FFFF0, 32'hFFFB567F, 32'hA5A5A5A5, 32'h0, 4'd6},  // R6
        '{9'h150, 32'h00000001, 32'h0F0FFFF0, 32'hFFFB567F, 32'hA5A5A5A5, 32'h00000001, 4'd6},  // R6
        '{9'h15C, 32'h80000001, 32'h0F0FFFF0, 32'hFFFB567F, 32'hA5A5A5A5, 32'h80000000, 4'd5},  // R5
        '{9'h154, 32'h0000FF00, 32'h0F0FFFF0, 32'hFFFB567F, 32'hA5A5A5A5, 32'h8000FF00, 4'd3},  // R3
        '{9'h158, 32'h8000F000, 32'h0F0FFFF0, 32'hFFFB567F, 32'hA5A5A5A5, 32'h00000F00, 4'd4},  // R4
        '{9'h14C, 32'hFFFFFFFF, 32'h0F0FFFF0, 32'hFFFB567F, 32'h5A5A5A5A, 32'h00000F00, 4'd5},  // R5
        '{9'h160, 32'hFFFFFFFF, 32'h0F0FFFF0, 32'hFFFB567F, 32'h5A5A5A5A, 32'h00000F00, 4'd8},  // R8
        '{9'h070, 32'hFFFFFFFF, 32'h0F0FFFF0, 32'hFFFB567F, 32'h5A5A5A5A, 32'h00000F00, 4'd8}   // R8
    };

    task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic lb_write(input logic [8:0] a, input logic [31:0] d);
        @(negedge clk);
        lb_en = 1'b1; lb_we = 1'b1; lb_addr = a; lb_wdata = d;
        @(negedge clk);
        lb_en = 1'b0; lb_we = 1'b0;
    endtask

    task automatic lb_read(input logic [8:0] a, output logic [31:0] d);
        @(negedge clk);
        lb_en = 1'b1; lb_we = 1'b0; lb_addr = a;
        @(negedge clk);
        lb_en = 1'b0;
        d = lb_rdata;
    endtask

    task automatic pb_xfer(input logic w, input logic [8:0] a, input logic [31:0] d,
                           output logic [31:0] rd);
        @(negedge clk);
        pb_valid = 1'b1; pb_write = w; pb_addr = a; pb_wdata = d;
        @(negedge clk);
        rd = pb_rdata;
        @(negedge clk);
        pb_valid = 1'b0; pb_write = 1'b0;
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
        $finish;
    end

    initial begin : stim
        logic [31:0] rd;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check("R1", {oe_out, ov_out}, 128'h0);
        check("R1", {95'h0, pb_ready, lb_rdata}, 128'h0);

        for (int i = 0; i < NV; i++) begin
            lb_write(VECS[i].addr, VECS[i].data);
            n_chk++;
            if ({oe_out[31:0], ov_out[31:0], oe_out[63:32], ov_out[63:32]} !==
                {VECS[i].oe0, VECS[i].ov0, VECS[i].oe1, VECS[i].ov1}) begin
                n_err++;
                $display("FAIL R%0d row %0d actual=%h_%h_%h_%h expected=%h_%h_%h_%h",
                         VECS[i].req, i, oe_out[31:0], ov_out[31:0], oe_out[63:32], ov_out[63:32],
                         VECS[i].oe0, VECS[i].ov0, VECS[i].oe1, VECS[i].ov1);
            end
        end

        // R7 local reads: pin value and write-only aliases
        pin_in = {32'hCAFE0001, 32'h13572468};
        repeat (3) @(negedge clk);
        lb_read(9'h060, rd); check("R7", 128'(rd), 128'h13572468);
        lb_read(9'h160, rd); check("R7", 128'(rd), 128'hCAFE0001);
        lb_read(9'h050, rd); check("R7", 128'(rd), 128'h0);
        lb_read(9'h14C, rd); check("R7", 128'(rd), 128'h0);

        // R12 synchronizer delay, sampled with back-to-back reads
        @(negedge clk);
        pin_in[31:0] = 32'h0000FFFF;
        lb_en = 1'b1; lb_we = 1'b0; lb_addr = 9'h060;
        @(negedge clk); check("R12", 128'(lb_rdata), 128'h13572468);
        @(negedge clk); check("R12", 128'(lb_rdata), 128'h13572468);
        @(negedge clk); check("R12", 128'(lb_rdata), 128'h0000FFFF);
        lb_en = 1'b0;

        // R13 toggle held on consecutive cycles (ov0 bit 0 starts at 1)
        @(negedge clk);
        lb_en = 1'b1; lb_we = 1'b1; lb_addr = 9'h05C; lb_wdata = 32'h1;
        @(negedge clk); check("R13", 128'(ov_out[0]), 128'h0);
        @(negedge clk); check("R13", 128'(ov_out[0]), 128'h1);
        @(negedge clk); check("R13", 128'(ov_out[0]), 128'h0);
        lb_en = 1'b0; lb_we = 1'b0;
        // ov0 now FFFB567E

        // R9 peripheral write with one wait state
        @(negedge clk);
        pb_valid = 1'b1; pb_write = 1'b1; pb_addr = 9'h050; pb_wdata = 32'h00C0FFEE;
        #1 check("R9", 128'(pb_ready), 128'h0);
        @(negedge clk);
        check("R9", 128'(pb_ready), 128'h1);
        check("R9", 128'(ov_out[31:0]), 128'hFFFB567E);
        @(negedge clk);
        pb_valid = 1'b0; pb_write = 1'b0;
        check("R9", 128'(ov_out[31:0]), 128'h00C0FFEE);
        check("R9", 128'(pb_ready), 128'h0);
        pb_xfer(1'b1, 9'h144, 32'h0000000F, rd);
        check("R9", 128'(oe_out[63:32]), 128'h5A5A5A5F);
        pb_xfer(1'b1, 9'h060, 32'hFFFFFFFF, rd);
        check("R8", {oe_out, ov_out}, {32'h5A5A5A5F, 32'h0F0FFFF0, 32'h00000F00, 32'h00C0FFEE});

        // R10 peripheral read mirror
        pb_xfer(1'b0, 9'h040, 32'h0, rd); check("R10", 128'(rd), 128'h0F0FFFF0);
        pb_xfer(1'b0, 9'h150, 32'h0, rd); check("R10", 128'(rd), 128'h00000F00);
        pb_xfer(1'b0, 9'h160, 32'h0, rd); check("R10", 128'(rd), 128'hCAFE0001);
        pb_xfer(1'b0, 9'h054, 32'h0, rd); check("R10", 128'(rd), 128'h0);

        // R11 same-edge collision: peripheral load, then local toggle
        @(negedge clk);
        pb_valid = 1'b1; pb_write = 1'b1; pb_addr = 9'h050; pb_wdata = 32'h000000FF;
        @(negedge clk);
        lb_en = 1'b1; lb_we = 1'b1; lb_addr = 9'h05C; lb_wdata = 32'h0000000F;
        @(negedge clk);
        pb_valid = 1'b0; lb_en = 1'b0; lb_we = 1'b0; pb_write = 1'b0;
        check("R11", 128'(ov_out[31:0]), 128'h000000F0);

        // R11 disjoint set (peripheral) and clear (local) on enable
        @(negedge clk);
        pb_valid = 1'b1; pb_write = 1'b1; pb_addr = 9'h044; pb_wdata = 32'h80000000;
        @(negedge clk);
        lb_en = 1'b1; lb_we = 1'b1; lb_addr = 9'h048; lb_wdata = 32'h00000010;
        @(negedge clk);
        pb_valid = 1'b0; lb_en = 1'b0; lb_we = 1'b0; pb_write = 1'b0;
        check("R11", 128'(oe_out[31:0]), 128'h8F0FFFE0);

        // R1 reset again clears everything
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        check("R1", {oe_out, ov_out}, 128'h0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
        $finish;
    end

endmodule